// File: doc/BRIEF.md
# Image Scaler Control and Interrupt Registers

This block is the control and status front end of an image-scaling engine. Software uses it through a plain 32-bit register bus. It launches one processing run with a start command, or it puts the engine through a self-timed soft reset. It keeps a word of interrupt causes, and a level interrupt line follows the enabled causes. The scaling datapath and its memory traffic are not part of the block. They appear only as event inputs: frame end, plus one pulse input for each illegal-parameter cause.

The block also contains a watchdog. The watchdog is armed by the start command. It counts down a programmed value, taking one step every 2^divider clocks. If the frame has not ended when the count runs out, the watchdog raises its own timeout cause.

The register window is selected by a 2-bit word index:

| Index | Register |
|---|---|
| 0 | command |
| 1 | interrupt enable |
| 2 | interrupt status |
| 3 | watchdog setup |

Reads are combinational on the index.

Top module: `sclr_ctrl_regs`

## Requirements
- R1: After the synchronous reset, all four registers read 0, and `start_pulse`, `eng_reset` and `irq` are low.
- R2: Writing the command register (index 0) with bit 0 set and bit 1 clear drives `start_pulse` high for the cycle that follows the write edge. Bit 0 always reads back as 0.
- R3: Writing the command register with bit 1 set starts a soft reset. `eng_reset` is then high for exactly 8 cycles, and bit 1 of the command register reads 1 for that time and 0 afterwards. Command writes made during the soft reset have no effect.
- R4: A soft reset clears the status word and disarms the watchdog. Events that arrive during it are dropped. The interrupt-enable register keeps its value.
- R5: The interrupt-enable register (index 1) is a full 32-bit read/write register. Writing 1 reads back as 1.
- R6: Event inputs set status bits (index 2). Frame end sets bit 0, watchdog timeout sets bit 1, and error input i sets bit 2+i, for 24 error inputs. A set bit holds until it is cleared.
- R7: Writing the status register clears exactly the bits written as 1. If an event sets a bit in the same cycle as a write that clears it, the bit stays set.
- R8: `irq` is high exactly when (status AND enable) is non-zero. An enable of 0 masks every cause.
- R9: The watchdog setup register (index 3) holds the count value in bits 15:0, the divider in bits 19:16 and the enable in bit 31. All other bits read 0.
- R10: A start with the watchdog enabled loads the count value V and the divider D. Status bit 1 is set exactly V*2^D cycles after the start write edge. A V of 0 behaves as 1.
- R11: A frame-end event while the watchdog is armed disarms it, and no timeout follows.
- R12: A start with the watchdog enable at 0 never produces a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| evt_frame_end | input | 1 | Frame-complete pulse from the engine |
| evt_err | input | 24 | Illegal-parameter cause pulses |
| start_pulse | output | 1 | One-cycle run launch |
| eng_reset | output | 1 | Engine reset, high during the soft reset |
| irq | output | 1 | Level interrupt |

## Verification
The bench measures the watchdog expiry to the exact cycle for several divider settings, including a count value of zero. A prescaler that is off by one, or a count that wraps, moves the timeout bit by one tick or more. The bench also makes an event and a clearing write collide in the same cycle; a design that lets the clear win loses the frame-end cause. Finally, it fires a start, an error and a watchdog expiry during a soft reset, and counts how long the reset lasts. A reset sequence that runs the wrong length, lets causes through, or wipes the enable register shows up at the ports.

// File: rtl/sclr_pkg.sv
package sclr_pkg;

    localparam int WORD_W     = 32;
    localparam int SEL_W      = 2;
    localparam int ERR_N      = 24;
    localparam int ST_FRAME   = 0;
    localparam int ST_TMO     = 1;
    localparam int ST_ERR0    = 2;
    localparam int STAT_W     = ST_ERR0 + ERR_N;
    localparam int CMD_START  = 0;
    localparam int CMD_SRST   = 1;
    localparam int TMO_VAL_W  = 16;
    localparam int TMO_DIV_W  = 4;
    localparam int TMO_DIV_LSB = 16;
    localparam int TMO_EN_BIT = 31;
    localparam int SRST_CYCLES = 8;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD   = 2'd0,
        SEL_IEN   = 2'd1,
        SEL_ISTAT = 2'd2,
        SEL_WDOG  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                 en;
        logic [TMO_DIV_W-1:0] div;
        logic [TMO_VAL_W-1:0] val;
    } wdog_cfg_t;

    function automatic wdog_cfg_t wdog_unpack(input logic [WORD_W-1:0] w);
        wdog_cfg_t c;
        c.en  = w[TMO_EN_BIT];
        c.div = w[TMO_DIV_LSB +: TMO_DIV_W];
        c.val = w[TMO_VAL_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] wdog_pack(input wdog_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[TMO_EN_BIT]                 = c.en;
        w[TMO_DIV_LSB +: TMO_DIV_W]   = c.div;
        w[TMO_VAL_W-1:0]              = c.val;
        return w;
    endfunction

endpackage

// File: rtl/sclr_reset_seq.sv
module sclr_reset_seq #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (req && cnt_q == '0) begin
            cnt_q <= CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/sclr_wdog.sv
module sclr_wdog
    import sclr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      arm,
    input  wdog_cfg_t cfg,
    input  logic      stop,
    output logic      expire,
    output logic      armed
);
    localparam int PRE_W = (1 << TMO_DIV_W) - 1;

    logic [TMO_VAL_W-1:0] cnt_q;
    logic [PRE_W-1:0]     pre_q;
    logic [TMO_DIV_W-1:0] div_q;
    logic                 armed_q;
    logic [PRE_W:0]       limit;
    logic                 tick;
    logic                 last;

    always_comb begin
        limit  = ({{PRE_W{1'b0}}, 1'b1} << div_q) - 1'b1;
        tick   = armed_q && ({1'b0, pre_q} == limit);
        last   = (cnt_q >> 1) == '0;
        expire = tick && last && !stop && !clear && !arm;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            pre_q   <= '0;
            div_q   <= '0;
        end else if (arm) begin
            armed_q <= cfg.en;
            cnt_q   <= cfg.val;
            div_q   <= cfg.div;
            pre_q   <= '0;
        end else if (armed_q) begin
            if (stop) begin
                armed_q <= 1'b0;
            end else if (tick) begin
                pre_q <= '0;
                if (last) armed_q <= 1'b0;
                else      cnt_q   <= cnt_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign armed = armed_q;
endmodule

// File: rtl/sclr_irq_stat.sv
module sclr_irq_stat #(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic [W-1:0] set_vec,
    input  logic         w1c_en,
    input  logic [W-1:0] w1c_mask,
    output logic [W-1:0] stat
);
    logic [W-1:0] stat_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clear)
                stat_q[i] <= 1'b0;
            else if (set_vec[i])
                stat_q[i] <= 1'b1;
            else if (w1c_en && w1c_mask[i])
                stat_q[i] <= 1'b0;
        end
    end

    assign stat = stat_q;
endmodule

// File: rtl/sclr_ctrl_regs.sv
module sclr_ctrl_regs
    import sclr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wen,
    input  logic [SEL_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              evt_frame_end,
    input  logic [ERR_N-1:0]  evt_err,
    output logic              start_pulse,
    output logic              eng_reset,
    output logic              irq
);
    reg_sel_e          sel;
    logic              busy;
    logic              wr_cmd;
    logic              rst_req;
    logic              start_req;
    logic              clr_all;
    logic              tmo_expire;
    logic              wd_armed;
    logic [WORD_W-1:0] ien_q;
    wdog_cfg_t         wdog_q;
    logic              start_q;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] stat;
    logic [WORD_W-1:0] stat_word;

    assign sel       = reg_sel_e'(bus_addr);
    assign wr_cmd    = bus_wen && (sel == SEL_CMD) && !busy;
    assign rst_req   = wr_cmd && bus_wdata[CMD_SRST];
    assign start_req = wr_cmd && bus_wdata[CMD_START] && !bus_wdata[CMD_SRST];
    assign clr_all   = rst_req || busy;

    sclr_reset_seq #(.CYCLES(SRST_CYCLES)) u_rst_seq (
        .clk  (clk),
        .rst  (rst),
        .req  (rst_req),
        .busy (busy)
    );

    sclr_wdog u_wdog (
        .clk    (clk),
        .rst    (rst),
        .clear  (clr_all),
        .arm    (start_req),
        .cfg    (wdog_q),
        .stop   (evt_frame_end),
        .expire (tmo_expire),
        .armed  (wd_armed)
    );

    always_comb begin
        set_vec                   = '0;
        set_vec[ST_FRAME]         = evt_frame_end;
        set_vec[ST_TMO]           = tmo_expire;
        set_vec[ST_ERR0 +: ERR_N] = evt_err;
    end

    sclr_irq_stat #(.W(STAT_W)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .clear    (clr_all),
        .set_vec  (set_vec),
        .w1c_en   (bus_wen && sel == SEL_ISTAT),
        .w1c_mask (bus_wdata[STAT_W-1:0]),
        .stat     (stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q   <= '0;
            wdog_q  <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= start_req;
            if (bus_wen && sel == SEL_IEN)  ien_q  <= bus_wdata;
            if (bus_wen && sel == SEL_WDOG) wdog_q <= wdog_unpack(bus_wdata);
        end
    end

    assign stat_word = WORD_W'(stat);

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CMD:   bus_rdata[CMD_SRST] = busy;
            SEL_IEN:   bus_rdata = ien_q;
            SEL_ISTAT: bus_rdata = stat_word;
            SEL_WDOG:  bus_rdata = wdog_pack(wdog_q);
            default:   bus_rdata = '0;
        endcase
    end

    assign start_pulse = start_q;
    assign eng_reset   = busy;
    assign irq         = |(stat_word & ien_q);
endmodule

// File: rtl/sclr_ctrl_chk.sv
module sclr_ctrl_chk
    import sclr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wen,
    input logic [SEL_W-1:0]  bus_addr,
    input logic              start_pulse,
    input logic              eng_reset,
    input logic              irq,
    input logic              evt_frame_end,
    input logic              rst_req,
    input logic [STAT_W-1:0] stat,
    input logic              wd_armed
);
    localparam int RL_W = $clog2(SRST_CYCLES + 2);

    logic [RL_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)            run_len <= '0;
        else if (eng_reset) run_len <= (run_len == RL_W'(SRST_CYCLES + 1)) ? run_len : run_len + 1'b1;
        else                run_len <= '0;
    end

    // R2: a launch pulse follows a command-register write
    a_r2_start_from_write: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> ($past(bus_wen) && $past(bus_addr) == 2'd0));

    // R3: engine reset never runs longer than the programmed length
    a_r3_reset_len: assert property (@(posedge clk) disable iff (rst)
        run_len <= RL_W'(SRST_CYCLES));

    // R3: no launch while the engine is held in reset
    a_r3_no_start_in_reset: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> !eng_reset);

    // R4: causes are cleared while resetting, so the line is quiet
    a_r4_no_irq_in_reset: assert property (@(posedge clk) disable iff (rst)
        eng_reset |-> !irq);

    // R6: frame end outside a reset always latches its cause
    a_r6_frame_latched: assert property (@(posedge clk) disable iff (rst)
        (evt_frame_end && !eng_reset && !rst_req) |=> stat[ST_FRAME]);

    // R10: the timeout cause only appears from an armed watchdog
    a_r10_tmo_from_armed: assert property (@(posedge clk) disable iff (rst)
        $rose(stat[ST_TMO]) |-> $past(wd_armed));
endmodule

bind sclr_ctrl_regs sclr_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_wen       (bus_wen),
    .bus_addr      (bus_addr),
    .start_pulse   (start_pulse),
    .eng_reset     (eng_reset),
    .irq           (irq),
    .evt_frame_end (evt_frame_end),
    .rst_req       (rst_req),
    .stat          (stat),
    .wd_armed      (wd_armed)
);

// File: tb/sclr_ctrl_regs_bench.sv
module sclr_ctrl_regs_bench;
    import sclr_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wen = 1'b0;
    logic [1:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              evt_frame_end = 1'b0;
    logic [23:0]       evt_err = '0;
    logic              start_pulse;
    logic              eng_reset;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sclr_ctrl_regs u_sclr_ctrl_regs (
        .clk           (clk),
        .rst           (rst),
        .bus_wen       (bus_wen),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .evt_frame_end (evt_frame_end),
        .evt_err       (evt_err),
        .start_pulse   (start_pulse),
        .eng_reset     (eng_reset),
        .irq           (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic fe, input logic [23:0] er);
        evt_frame_end = fe; evt_err = er;
        @(posedge clk); @(negedge clk);
        evt_frame_end = 1'b0; evt_err = '0;
    endtask

    function automatic logic [31:0] wdog_word(input logic en, input int div, input int val);
        return {en, 11'd0, div[3:0], val[15:0]};
    endfunction

    function automatic int expiry_cycles(input int div, input int val);
        return ((val == 0) ? 1 : val) << div;
    endfunction

    task automatic timeout_case(input int div, input int val);
        logic [31:0] d;
        int n;
        n = expiry_cycles(div, val);
        wr(SEL_ISTAT, 32'hFFFF_FFFF);
        wr(SEL_WDOG, wdog_word(1'b1, div, val));
        wr(SEL_CMD, 32'h1);
        repeat (n - 1) @(negedge clk);
        rd(SEL_ISTAT, d);
        chk("R10 timeout not early", {31'd0, d[1]}, 32'd0);
        @(negedge clk);
        rd(SEL_ISTAT, d);
        chk("R10 timeout on time", {31'd0, d[1]}, 32'd1);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp_stat;
        logic [31:0] en;
        int c;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 register zero after reset", d, 32'd0);
        end
        chk("R1 outputs low", {29'd0, start_pulse, eng_reset, irq}, 32'd0);

        // R5 enable read/write
        wr(SEL_IEN, 32'h1);
        rd(SEL_IEN, d);
        chk("R5 enable reads 1", d, 32'h1);
        wr(SEL_IEN, 32'hA5C3_5A3C);
        rd(SEL_IEN, d);
        chk("R5 enable full word", d, 32'hA5C3_5A3C);
        wr(SEL_IEN, 32'h0);

        // R2 start pulse
        wr(SEL_CMD, 32'h1);
        chk("R2 start pulse high", {31'd0, start_pulse}, 32'd1);
        rd(SEL_CMD, d);
        chk("R2 start bit reads 0", d, 32'd0);
        @(negedge clk);
        chk("R2 start pulse one cycle", {31'd0, start_pulse}, 32'd0);

        // R6 / R8 frame end with masking
        pulse(1'b1, '0);
        rd(SEL_ISTAT, d);
        chk("R6 frame end bit0", d, 32'h1);
        chk("R8 masked irq low", {31'd0, irq}, 32'd0);
        wr(SEL_IEN, 32'h1);
        chk("R8 irq high when enabled", {31'd0, irq}, 32'd1);
        wr(SEL_ISTAT, 32'h1);
        rd(SEL_ISTAT, d);
        chk("R7 w1c clears bit0", d, 32'h0);
        chk("R8 irq low after clear", {31'd0, irq}, 32'd0);

        // R7 same-cycle set and clear
        pulse(1'b1, 24'h1);
        bus_wen = 1'b1; bus_addr = SEL_ISTAT; bus_wdata = 32'h5; evt_frame_end = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wen = 1'b0; evt_frame_end = 1'b0;
        rd(SEL_ISTAT, d);
        chk("R7 event beats clear, other bit cleared", d, 32'h1);
        wr(SEL_ISTAT, 32'hFFFF_FFFF);

        // R6 / R7 / R8 random error causes
        exp_stat = 32'd0;
        for (int i = 0; i < 24; i++) begin
            logic [23:0] ev;
            logic [31:0] m;
            ev = 24'($urandom) & 24'($urandom);
            m  = $urandom & $urandom;
            en = $urandom & $urandom & $urandom;
            pulse(1'b0, ev);
            exp_stat = exp_stat | {6'd0, ev, 2'd0};
            rd(SEL_ISTAT, d);
            chk("R6 error causes latch", d, exp_stat);
            wr(SEL_ISTAT, m);
            exp_stat = exp_stat & ~m;
            wr(SEL_IEN, en);
            rd(SEL_ISTAT, d);
            chk("R7 w1c random mask", d, exp_stat);
            chk("R8 irq vs masked causes", {31'd0, irq}, {31'd0, |(exp_stat & en)});
        end
        wr(SEL_ISTAT, 32'hFFFF_FFFF);
        wr(SEL_IEN, 32'h0);

        // R9 watchdog field layout
        wr(SEL_WDOG, 32'hFFFF_FFFF);
        rd(SEL_WDOG, d);
        chk("R9 watchdog fields", d, 32'h800F_FFFF);

        // R10 expiry timing
        timeout_case(2, 3);
        timeout_case(0, 5);
        timeout_case(1, 0);
        timeout_case(3, 2);
        wr(SEL_IEN, 32'h2);
        chk("R8 timeout drives irq", {31'd0, irq}, 32'd1);
        wr(SEL_IEN, 32'h0);

        // R11 frame end disarms
        wr(SEL_ISTAT, 32'hFFFF_FFFF);
        wr(SEL_WDOG, wdog_word(1'b1, 1, 4));
        wr(SEL_CMD, 32'h1);
        repeat (3) @(negedge clk);
        pulse(1'b1, '0);
        repeat (20) @(negedge clk);
        rd(SEL_ISTAT, d);
        chk("R11 no timeout after frame end", d, 32'h1);

        // R12 disabled watchdog
        wr(SEL_ISTAT, 32'hFFFF_FFFF);
        wr(SEL_WDOG, wdog_word(1'b0, 0, 2));
        wr(SEL_CMD, 32'h1);
        repeat (20) @(negedge clk);
        rd(SEL_ISTAT, d);
        chk("R12 no timeout when disabled", d, 32'h0);

        // R3 / R4 soft reset
        wr(SEL_IEN, 32'h0000_00F3);
        pulse(1'b1, 24'h3);
        wr(SEL_WDOG, wdog_word(1'b1, 0, 4));
        wr(SEL_CMD, 32'h1);
        wr(SEL_CMD, 32'h2);
        rd(SEL_CMD, d);
        chk("R3 reset bit reads 1", d, 32'h2);
        bus_wen = 1'b1; bus_addr = SEL_CMD; bus_wdata = 32'h1;
        evt_err = 24'hFF;
        @(posedge clk); @(negedge clk);
        bus_wen = 1'b0; evt_err = '0;
        chk("R3 start ignored in reset", {31'd0, start_pulse}, 32'd0);
        c = 2;
        while (eng_reset && c < 40) begin
            @(negedge clk);
            if (eng_reset) c++;
        end
        chk("R3 reset length", c, 8);
        rd(SEL_CMD, d);
        chk("R3 reset bit clears", d, 32'h0);
        repeat (10) @(negedge clk);
        rd(SEL_ISTAT, d);
        chk("R4 status cleared, timer disarmed", d, 32'h0);
        rd(SEL_IEN, d);
        chk("R4 enable kept", d, 32'h0000_00F3);
        chk("R4 irq low after reset", {31'd0, irq}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule